// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Sequencer

This block steers one DMA channel through a chain of control blocks stored in memory. Software writes the pointer to the first control block, then sets the run bit in the channel's control/status word. The sequencer reads the eight-word control block through a single-word memory read port. It hands the transfer fields to an external data-moving engine and waits for that engine to report completion. It then either follows the block's link pointer or stops when the link is zero.

Pointers carry a byte address shifted right by five, so every control block sits on a 32-byte boundary. A link may point back to an earlier block, which makes a ring of buffers that runs until software cancels it. Each control block can ask for an interrupt on its own completion, so a ring raises one interrupt per buffer. Bus errors, an abort request and a debug-register reset all stop the channel. The data engine and the bus fabric are outside the block and appear only as request/done handshakes.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset the status word reads 0, the pointer reads 0, irq is low and neither mem_req nor xfer_req is asserted. Register select 0 is status, 1 is the descriptor pointer and 2 is the debug register. The debug register reads the version value 1 in bits 31:28.
- R2: A status write with bit 0 set, bit 30 clear and a nonzero pointer, made while the channel is idle, starts the channel. Status bit 0 (ACTIVE) reads 1 while it runs. Bits 19:16 (QoS), 23:20 (panic QoS) and 28 (wait-for-writes) take the written values at that moment.
- R3: A control block is fetched one word at a time from byte address (pointer << 5) + 4*k, for k = 0 to 7. The words are, in order: transfer info, source address, source info, destination address, destination info, length, link pointer and a reserved word. Only one of mem_req and xfer_req is high at a time, and mem_addr holds steady until mem_valid.
- R4: After the fetch, the six transfer fields appear on the xfer_* outputs with xfer_req held high until xfer_done.
- R5: When a transfer completes with a nonzero link, the pointer register takes the link value and the next block is fetched. When the link is zero, ACTIVE clears and END (status bit 1) is set.
- R6: A link that points back to an earlier block runs the blocks as a ring, in order, until software cancels it.
- R7: When bit 0 of a block's transfer-info word is set, INT (status bit 2) and irq become 1 after that block ends. When the bit is clear, INT is left unchanged.
- R8: A status write clears each of END, INT and ERROR whose bit is 1 in the written value. Writing back a value read while the channel runs does not restart the channel or disturb it.
- R9: A status write of zero stops the channel: ACTIVE clears, END is not set and no further transfer starts.
- R10: A status write with bit 30 set drops the current block, clears ACTIVE and sets HALT (bit 31), and the link is not followed.
- R11: An error on mem_err during a fetch, or on xfer_err with xfer_done, sets ERROR (bit 10) and HALT and stops the chain. INT is raised as well if bit 0 of the transfer-info word fetched for that block is set; this word is cleared at the start of each fetch.
- R12: A debug-register write with bit 23 set returns the channel to idle and clears every status flag and the pointer.
- R13: A start request while the pointer is zero fetches nothing and sets END at once.
- R14: While the channel is active, pointer writes, start requests and QoS values in status writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 status, 1 pointer, 2 debug |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register |
| mem_req | output | 1 | Control-block word read request |
| mem_addr | output | ADDR_W | Byte address of the word being read |
| mem_valid | input | 1 | Read response valid |
| mem_err | input | 1 | Read response carries a bus error |
| mem_rdata | input | 32 | Read response data |
| xfer_req | output | 1 | Transfer request to the data engine |
| xfer_tinfo | output | 32 | Transfer-info word |
| xfer_src_addr | output | 32 | Source address |
| xfer_src_info | output | 32 | Source info word |
| xfer_dst_addr | output | 32 | Destination address |
| xfer_dst_info | output | 32 | Destination info word |
| xfer_len | output | 32 | Transfer length word |
| xfer_done | input | 1 | Data engine finished the transfer |
| xfer_err | input | 1 | Transfer ended with an error (valid with xfer_done) |
| irq | output | 1 | Interrupt, high while INT is set |

## Verification
Several properties are checked on every cycle. The memory and transfer handshakes never overlap, and the fetch address and transfer fields stay stable while a handshake is pending. ACTIVE always matches an outstanding request. Every rising edge of irq follows a completion or an error, and END only rises with the channel idle. The bench scenarios have to show the rest: the order of the fetched words, following links through chains and rings, and the effects of cancel, abort, debug reset, the error paths and the write-one-to-clear acknowledge. These need prepared memory contents and known register values.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_FETCH,
    SEQ_XFER
  } seq_state_e;

  // register selects
  localparam logic [1:0] SEL_CS  = 2'd0;
  localparam logic [1:0] SEL_PTR = 2'd1;
  localparam logic [1:0] SEL_DBG = 2'd2;

  // status word bit positions
  localparam int unsigned BIT_ACT   = 0;
  localparam int unsigned BIT_END   = 1;
  localparam int unsigned BIT_INT   = 2;
  localparam int unsigned BIT_ERR   = 10;
  localparam int unsigned BIT_WFOW  = 28;
  localparam int unsigned BIT_ABORT = 30;
  localparam int unsigned BIT_HALT  = 31;
  localparam int unsigned QOS_LO    = 16;
  localparam int unsigned PQOS_LO   = 20;

  // debug register
  localparam int unsigned BIT_DBG_RST = 23;
  localparam logic [3:0]  CHAN_VERSION = 4'd1;

  typedef struct packed {
    logic [31:0] tinfo;
    logic [31:0] src_lo;
    logic [31:0] src_info;
    logic [31:0] dst_lo;
    logic [31:0] dst_info;
    logic [31:0] len;
    logic [31:0] next;
  } cblk_t;

  typedef struct packed {
    logic       halt;
    logic       wfow;
    logic [3:0] pqos;
    logic [3:0] qos;
    logic       err;
    logic       intr;
    logic       done;
  } chan_flags_t;

endpackage

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch
  import dma_chain_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned ALIGN_SH = 5,
  parameter int unsigned WORDS    = 8,
  localparam int unsigned PTR_W   = ADDR_W - ALIGN_SH,
  localparam int unsigned CNT_W   = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_wr_en,
  input  logic [PTR_W-1:0]  ptr_wdata,
  input  logic              ptr_clr,
  input  logic              ptr_follow,
  input  logic              fetch_begin,
  input  logic              word_take,
  input  logic [31:0]       mem_rdata,
  output logic [PTR_W-1:0]  ptr_q,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              last_word,
  output cblk_t             cblk_q
);

  logic [PTR_W-1:0] ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  cblk_t            cblk_d;

  assign mem_addr  = {ptr_q, {ALIGN_SH{1'b0}}} + ADDR_W'({cnt_q, 2'b00});
  assign last_word = word_take && (cnt_q == CNT_W'(WORDS - 1));

  always_comb begin
    ptr_d  = ptr_q;
    cnt_d  = cnt_q;
    cblk_d = cblk_q;
    if (ptr_clr)         ptr_d = '0;
    else if (ptr_follow) ptr_d = cblk_q.next[PTR_W-1:0];
    else if (ptr_wr_en)  ptr_d = ptr_wdata;

    if (fetch_begin) begin
      cnt_d        = '0;
      cblk_d.tinfo = '0;
    end else if (word_take) begin
      cnt_d = cnt_q + 1'b1;
      case (int'(cnt_q))
        0:       cblk_d.tinfo    = mem_rdata;
        1:       cblk_d.src_lo   = mem_rdata;
        2:       cblk_d.src_info = mem_rdata;
        3:       cblk_d.dst_lo   = mem_rdata;
        4:       cblk_d.dst_info = mem_rdata;
        5:       cblk_d.len      = mem_rdata;
        6:       cblk_d.next     = mem_rdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      cnt_q  <= '0;
      cblk_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      cnt_q  <= cnt_d;
      cblk_q <= cblk_d;
    end
  end

endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dma_chain_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic        seq_idle,
  input  logic        ptr_zero,
  input  logic        ev_end,
  input  logic        ev_int,
  input  logic        ev_err,
  output logic        cmd_start,
  output logic        cmd_stop,
  output logic        dbg_reset,
  output chan_flags_t flags_q
);

  chan_flags_t flags_d;
  logic cs_wr, abort_req, cancel_req, go_req, empty_start;

  assign cs_wr       = reg_wr && (reg_addr == SEL_CS);
  assign dbg_reset   = reg_wr && (reg_addr == SEL_DBG) && reg_wdata[BIT_DBG_RST];
  assign abort_req   = cs_wr && reg_wdata[BIT_ABORT];
  assign cancel_req  = cs_wr && (reg_wdata == 32'd0);
  assign go_req      = cs_wr && reg_wdata[BIT_ACT] && !reg_wdata[BIT_ABORT] && seq_idle;
  assign cmd_start   = go_req && !ptr_zero;
  assign empty_start = go_req && ptr_zero;
  assign cmd_stop    = abort_req || cancel_req;

  always_comb begin
    flags_d = flags_q;
    if (dbg_reset) begin
      flags_d = '0;
    end else begin
      if (cs_wr) begin
        if (reg_wdata[BIT_END]) flags_d.done = 1'b0;
        if (reg_wdata[BIT_INT]) flags_d.intr = 1'b0;
        if (reg_wdata[BIT_ERR]) flags_d.err  = 1'b0;
      end
      if (go_req) begin
        flags_d.qos  = reg_wdata[QOS_LO +: 4];
        flags_d.pqos = reg_wdata[PQOS_LO +: 4];
        flags_d.wfow = reg_wdata[BIT_WFOW];
        flags_d.halt = 1'b0;
      end
      if (abort_req) flags_d.halt = 1'b1;
      if (ev_end || empty_start) flags_d.done = 1'b1;
      if (ev_int) flags_d.intr = 1'b1;
      if (ev_err) begin
        flags_d.err  = 1'b1;
        flags_d.halt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_chain_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned ALIGN_SH = 5,
  parameter int unsigned WORDS    = 8,
  localparam int unsigned PTR_W   = ADDR_W - ALIGN_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic              mem_err,
  input  logic [31:0]       mem_rdata,
  output logic              xfer_req,
  output logic [31:0]       xfer_tinfo,
  output logic [31:0]       xfer_src_addr,
  output logic [31:0]       xfer_src_info,
  output logic [31:0]       xfer_dst_addr,
  output logic [31:0]       xfer_dst_info,
  output logic [31:0]       xfer_len,
  input  logic              xfer_done,
  input  logic              xfer_err,
  output logic              irq
);

  seq_state_e  state_q, state_d;
  chan_flags_t flags;
  cblk_t       cblk;
  logic [PTR_W-1:0] ptr;
  logic cmd_start, cmd_stop, dbg_reset, stop;
  logic ev_end, ev_int, ev_err;
  logic fetch_begin, ptr_follow, word_take, last_word, ptr_wr_en;
  logic st_active, end_f;

  assign stop      = cmd_stop || dbg_reset;
  assign st_active = (state_q != SEQ_IDLE);
  assign end_f     = flags.done;
  assign word_take = (state_q == SEQ_FETCH) && mem_valid && !mem_err && !stop;
  assign ptr_wr_en = reg_wr && (reg_addr == SEL_PTR) && !st_active;

  dma_chan_csr u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .seq_idle  (!st_active),
    .ptr_zero  (ptr == '0),
    .ev_end    (ev_end),
    .ev_int    (ev_int),
    .ev_err    (ev_err),
    .cmd_start (cmd_start),
    .cmd_stop  (cmd_stop),
    .dbg_reset (dbg_reset),
    .flags_q   (flags)
  );

  dma_desc_fetch #(
    .ADDR_W   (ADDR_W),
    .ALIGN_SH (ALIGN_SH),
    .WORDS    (WORDS)
  ) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .ptr_wr_en   (ptr_wr_en),
    .ptr_wdata   (reg_wdata[PTR_W-1:0]),
    .ptr_clr     (dbg_reset),
    .ptr_follow  (ptr_follow),
    .fetch_begin (fetch_begin),
    .word_take   (word_take),
    .mem_rdata   (mem_rdata),
    .ptr_q       (ptr),
    .mem_addr    (mem_addr),
    .last_word   (last_word),
    .cblk_q      (cblk)
  );

  // sequencer next state
  always_comb begin
    state_d     = state_q;
    fetch_begin = 1'b0;
    ptr_follow  = 1'b0;
    ev_end      = 1'b0;
    ev_int      = 1'b0;
    ev_err      = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (cmd_start) begin
          state_d     = SEQ_FETCH;
          fetch_begin = 1'b1;
        end
      end
      SEQ_FETCH: begin
        if (stop) begin
          state_d = SEQ_IDLE;
        end else if (mem_valid && mem_err) begin
          state_d = SEQ_IDLE;
          ev_err  = 1'b1;
          ev_int  = cblk.tinfo[0];
        end else if (last_word) begin
          state_d = SEQ_XFER;
        end
      end
      SEQ_XFER: begin
        if (stop) begin
          state_d = SEQ_IDLE;
        end else if (xfer_done) begin
          ev_int = cblk.tinfo[0];
          if (xfer_err) begin
            state_d = SEQ_IDLE;
            ev_err  = 1'b1;
          end else if (cblk.next == 32'd0) begin
            state_d = SEQ_IDLE;
            ev_end  = 1'b1;
          end else begin
            state_d     = SEQ_FETCH;
            ptr_follow  = 1'b1;
            fetch_begin = 1'b1;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
    if (dbg_reset) state_d = SEQ_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  assign mem_req       = (state_q == SEQ_FETCH);
  assign xfer_req      = (state_q == SEQ_XFER);
  assign xfer_tinfo    = cblk.tinfo;
  assign xfer_src_addr = cblk.src_lo;
  assign xfer_src_info = cblk.src_info;
  assign xfer_dst_addr = cblk.dst_lo;
  assign xfer_dst_info = cblk.dst_info;
  assign xfer_len      = cblk.len;
  assign irq           = flags.intr;

  always_comb begin
    unique case (reg_addr)
      SEL_CS:  reg_rdata = {flags.halt, 2'b00, flags.wfow, 4'b0000, flags.pqos, flags.qos,
                            5'b00000, flags.err, 7'b0000000, flags.intr, flags.done, st_active};
      SEL_PTR: reg_rdata = 32'(ptr);
      SEL_DBG: reg_rdata = {CHAN_VERSION, 28'd0};
      default: reg_rdata = 32'd0;
    endcase
  end

endmodule

// File: rtl/dma_chain_seq_chk.sv
module dma_chain_seq_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_valid,
  input logic              mem_err,
  input logic              xfer_req,
  input logic              xfer_done,
  input logic [31:0]       xfer_src_addr,
  input logic              irq,
  input logic              st_active,
  input logic              st_end
);

  assert_one_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && xfer_req));

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (!mem_req || $stable(mem_addr)));

  assert_fields_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_done) |=> (!xfer_req || $stable(xfer_src_addr)));

  assert_active_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st_active == (mem_req || xfer_req));

  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(xfer_done || (mem_valid && mem_err)));

  assert_end_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_end) |-> !st_active);

endmodule

bind dma_chain_seq dma_chain_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mem_req       (mem_req),
  .mem_addr      (mem_addr),
  .mem_valid     (mem_valid),
  .mem_err       (mem_err),
  .xfer_req      (xfer_req),
  .xfer_done     (xfer_done),
  .xfer_src_addr (xfer_src_addr),
  .irq           (irq),
  .st_active     (st_active),
  .st_end        (end_f)
);

// File: tb/dma_chain_seq_test.sv
module dma_chain_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_valid = 1'b0;
  logic        mem_err = 1'b0;
  logic [31:0] mem_rdata = 32'd0;
  logic        xfer_req;
  logic [31:0] xfer_tinfo, xfer_src_addr, xfer_src_info, xfer_dst_addr, xfer_dst_info, xfer_len;
  logic        xfer_done = 1'b0;
  logic        xfer_err = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] mem [0:255];
  int          err_on = 0;
  logic [31:0] err_addr = 32'd0;
  logic [31:0] mlog [0:63];
  int          mcount = 0;
  int          xdelay = 0;
  int          xinject = 0;
  int          xwait = 0;
  logic [31:0] xlog_src [0:15];
  logic [31:0] last_tinfo, last_sinfo, last_dst, last_dinfo, last_len;
  int          xcount = 0;

  always #5 clk = ~clk;

  dma_chain_seq uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_err(mem_err), .mem_rdata(mem_rdata), .xfer_req(xfer_req), .xfer_tinfo(xfer_tinfo),
    .xfer_src_addr(xfer_src_addr), .xfer_src_info(xfer_src_info), .xfer_dst_addr(xfer_dst_addr),
    .xfer_dst_info(xfer_dst_info), .xfer_len(xfer_len), .xfer_done(xfer_done),
    .xfer_err(xfer_err), .irq(irq)
  );

  // memory model: one word answered per cycle
  always @(negedge clk) begin
    mem_valid = mem_req;
    mem_rdata = mem[mem_addr[9:2]];
    mem_err   = mem_req && (err_on != 0) && (mem_addr == err_addr);
    if (mem_req) begin
      if (mcount < 64) mlog[mcount] = mem_addr;
      mcount++;
    end
  end

  // transfer engine model
  always @(negedge clk) begin
    if (xfer_req && !xfer_done) begin
      if (xwait >= xdelay) begin
        xfer_done = 1'b1;
        xfer_err  = (xinject != 0);
        if (xcount < 16) xlog_src[xcount] = xfer_src_addr;
        last_tinfo = xfer_tinfo; last_sinfo = xfer_src_info; last_dst = xfer_dst_addr;
        last_dinfo = xfer_dst_info; last_len = xfer_len;
        xcount++;
      end else begin
        xwait++;
      end
    end else begin
      xfer_done = 1'b0;
      xfer_err  = 1'b0;
      xwait     = 0;
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: run hung, got timeout expected completion");
    n_fail++;
    finish_run();
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 32'd0;
  endtask

  task automatic reg_read(logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    reg_addr = sel;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      reg_read(2'd0, s);
      if (s[0] == 1'b0) break;
    end
  endtask

  task automatic put_cblk(int p, logic [31:0] ti, logic [31:0] nxt);
    mem[p*8+0] = ti;
    mem[p*8+1] = 32'h1000_0000 + p;
    mem[p*8+2] = 32'h0000_5000 + p;
    mem[p*8+3] = 32'h2000_0000 + p;
    mem[p*8+4] = 32'h0000_6000 + p;
    mem[p*8+5] = 32'h0000_0100 + p;
    mem[p*8+6] = nxt;
    mem[p*8+7] = 32'hDEAD_0000 + p;
  endtask

  task automatic clear_flags();
    reg_write(2'd0, 32'h0000_0406);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    reg_read(2'd0, v); check("R1 status", v, 32'd0);
    reg_read(2'd1, v); check("R1 pointer", v, 32'd0);
    reg_read(2'd2, v); check("R1 version", v, 32'h1000_0000);
    check("R1 irq/req", {29'd0, irq, mem_req, xfer_req}, 32'd0);
  endtask

  task automatic t_single();
    logic [31:0] v;
    int m0;
    put_cblk(2, 32'h0000_0001, 32'd0);
    reg_write(2'd1, 32'd2);
    m0 = mcount;
    reg_write(2'd0, 32'h1095_0001);
    reg_read(2'd0, v); check("R2 active after start", {31'd0, v[0]}, 32'd1);
    wait_idle();
    for (int k = 0; k < 8; k++) check("R3 fetch address order", mlog[m0+k], 32'h40 + 4*k);
    check("R3 fetch word count", mcount - m0, 32'd8);
    check("R4 src", xlog_src[xcount-1], 32'h1000_0002);
    check("R4 src info", last_sinfo, 32'h5002);
    check("R4 dst", last_dst, 32'h2000_0002);
    check("R4 dst info", last_dinfo, 32'h6002);
    check("R4 len", last_len, 32'h102);
    check("R4 tinfo", last_tinfo, 32'h1);
    reg_read(2'd0, v);
    check("R5 R7 R2 status after single", v, 32'h1095_0006);
    check("R7 irq", {31'd0, irq}, 32'd1);
    reg_write(2'd0, v);
    reg_read(2'd0, v);
    check("R8 ack clears INT END, no restart", v, 32'h1095_0000);
    check("R8 irq low", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_chain();
    logic [31:0] v;
    int x0;
    put_cblk(3, 32'd0, 32'd5);
    put_cblk(5, 32'd0, 32'd4);
    put_cblk(4, 32'd0, 32'd0);
    x0 = xcount;
    reg_write(2'd1, 32'd3);
    reg_write(2'd0, 32'h0000_0001);
    wait_idle();
    check("R5 chain transfers", xcount - x0, 32'd3);
    check("R5 chain order 0", xlog_src[x0],   32'h1000_0003);
    check("R5 chain order 1", xlog_src[x0+1], 32'h1000_0005);
    check("R5 chain order 2", xlog_src[x0+2], 32'h1000_0004);
    reg_read(2'd1, v); check("R5 pointer follows link", v, 32'd4);
    reg_read(2'd0, v); check("R7 no INT without enable", v, 32'h0000_0002);
    clear_flags();
  endtask

  task automatic t_ring();
    logic [31:0] v;
    int x0, irqs, xa;
    put_cblk(6, 32'd1, 32'd7);
    put_cblk(7, 32'd1, 32'd6);
    x0 = xcount; irqs = 0;
    reg_write(2'd1, 32'd6);
    reg_write(2'd0, 32'h0001_0001);
    for (int i = 0; i < 2000 && irqs < 4; i++) begin
      @(negedge clk);
      if (irq) begin
        irqs++;
        reg_read(2'd0, v);
        check("R8 active while ring runs", {31'd0, v[0]}, 32'd1);
        reg_write(2'd0, v);
      end
    end
    check("R6 ring irq count", irqs, 32'd4);
    check("R6 ring order 0", xlog_src[x0],   32'h1000_0006);
    check("R6 ring order 1", xlog_src[x0+1], 32'h1000_0007);
    check("R6 ring order 2", xlog_src[x0+2], 32'h1000_0006);
    check("R6 ring order 3", xlog_src[x0+3], 32'h1000_0007);
    reg_write(2'd0, 32'd0);
    xa = xcount;
    repeat (40) @(negedge clk);
    reg_read(2'd0, v);
    check("R9 cancel stops, no END", v & 32'h0000_0003, 32'd0);
    check("R9 no transfer after cancel", xcount - xa, 32'd0);
    clear_flags();
  endtask

  task automatic t_busy_writes();
    logic [31:0] v;
    put_cblk(8, 32'd0, 32'd0);
    xdelay = 30;
    reg_write(2'd1, 32'd8);
    reg_write(2'd0, 32'h0032_0001);
    repeat (12) @(negedge clk);
    reg_write(2'd1, 32'd9);
    reg_read(2'd1, v); check("R14 pointer write ignored", v, 32'd8);
    reg_write(2'd0, 32'h00F7_0001);
    reg_read(2'd0, v); check("R14 QoS held", v & 32'h00FF_0001, 32'h0032_0001);
    wait_idle();
    xdelay = 0;
    reg_read(2'd0, v); check("R14 run completes", v, 32'h0032_0002);
    clear_flags();
  endtask

  task automatic t_abort();
    logic [31:0] v;
    int x0, m0;
    put_cblk(10, 32'd1, 32'd11);
    put_cblk(11, 32'd0, 32'd0);
    xdelay = 30;
    x0 = xcount;
    reg_write(2'd1, 32'd10);
    reg_write(2'd0, 32'h0000_0001);
    for (int i = 0; i < 100 && !xfer_req; i++) @(negedge clk);
    reg_write(2'd0, 32'h4000_0000);
    m0 = mcount;
    repeat (50) @(negedge clk);
    reg_read(2'd0, v);
    check("R10 abort status", v, 32'h8000_0000);
    check("R10 link not followed", mcount - m0, 32'd0);
    check("R10 transfer dropped", xcount - x0, 32'd0);
    xdelay = 0;
  endtask

  task automatic t_fetch_err();
    logic [31:0] v;
    int x0;
    put_cblk(12, 32'd1, 32'd0);
    err_on = 1; err_addr = 32'd12*32 + 12;
    x0 = xcount;
    reg_write(2'd1, 32'd12);
    reg_write(2'd0, 32'h0000_0001);
    wait_idle();
    err_on = 0;
    reg_read(2'd0, v);
    check("R11 fetch error status", v, 32'h8000_0404);
    check("R11 no transfer after fetch error", xcount - x0, 32'd0);
    reg_write(2'd0, 32'h0000_0404);
    reg_read(2'd0, v);
    check("R8 W1C ERROR INT", v, 32'h8000_0000);
  endtask

  task automatic t_xfer_err();
    logic [31:0] v;
    int x0;
    put_cblk(13, 32'd0, 32'd14);
    put_cblk(14, 32'd0, 32'd0);
    xinject = 1;
    x0 = xcount;
    reg_write(2'd1, 32'd13);
    reg_write(2'd0, 32'h0000_0001);
    wait_idle();
    xinject = 0;
    repeat (20) @(negedge clk);
    reg_read(2'd0, v);
    check("R11 transfer error status", v, 32'h8000_0400);
    check("R11 chain stops after error", xcount - x0, 32'd1);
  endtask

  task automatic t_dbg_reset();
    logic [31:0] v;
    int m0;
    put_cblk(15, 32'd0, 32'd0);
    xdelay = 40;
    reg_write(2'd1, 32'd15);
    reg_write(2'd0, 32'h0000_0001);
    repeat (15) @(negedge clk);
    reg_write(2'd2, 32'h0080_0000);
    reg_read(2'd0, v); check("R12 status cleared", v, 32'd0);
    reg_read(2'd1, v); check("R12 pointer cleared", v, 32'd0);
    check("R12 no request", {30'd0, mem_req, xfer_req}, 32'd0);
    xdelay = 0;
    m0 = mcount;
    reg_write(2'd0, 32'h0000_0001);
    repeat (5) @(negedge clk);
    reg_read(2'd0, v);
    check("R13 zero pointer start sets END", v, 32'h0000_0002);
    check("R13 no fetch", mcount - m0, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_chain();
    t_ring();
    t_busy_writes();
    t_abort();
    t_fetch_err();
    t_xfer_err();
    t_dbg_reset();
    finish_run();
  end

endmodule